// File: doc/BRIEF.md
# Signed Multi-Compare PWM Counter Core

This block produces two pulse-width-modulated outputs from one signed up-counter. The counter starts each period at a programmable start value and counts up, one step per prescaled tick, until it equals a programmable end value. On the next tick it returns to the start value. A further compare marks the midpoint of the period. Each output has its own set compare and its own clear compare. Because all compares are signed and independent, the same hardware gives edge-aligned, centre-aligned, signed and unsigned waveforms.

All seven programmable values are double-buffered. Writes land in a shadow copy. The shadow copy moves into the active set only after software raises a load-ok request. The move happens either on the next clock, or at selected midpoint and/or period-end opportunities, optionally only on every Nth opportunity. Besides the two raw outputs, the block gives one-cycle strobes for the midpoint and for the period end.

Top module: `pwm_cmp_core`

## Requirements
- R1: During and right after reset, `cnt`, `pwm_a`, `pwm_b`, `half_stb`, `full_stb` and `ldok` are all 0, and every active and shadow value is 0.
- R2: While `run` is high, a tick occurs in each cycle where the low `prsc` bits of a cycle count are all ones. The count starts at 0 when `run` rises, so ticks come every 2^`prsc` cycles. `cnt` changes only in the cycle after a tick.
- R3: On a tick, if `cnt` equals the active end value, `cnt` takes the start value. Otherwise `cnt` increments by one, in two's complement, so negative start values work.
- R4: While `run` is low, `cnt`, `pwm_a` and `pwm_b` hold their values.
- R5: On a tick, `pwm_a` becomes 1 in the next cycle if `cnt` equals the A-set value, and becomes 0 if `cnt` equals the A-clear value. `pwm_b` works the same way with the B-set and B-clear values.
- R6: When `cnt` matches both the set and the clear value of an output on a tick, the output becomes 0.
- R7: `half_stb` is high for one cycle after a tick at which `cnt` equals the midpoint value. `full_stb` is high for one cycle after a tick at which `cnt` equals the end value.
- R8: A write with `wr_en` stores `wr_data` in the shadow value chosen by `wr_sel`: 0 start, 1 midpoint, 2 end, 3 A-set, 4 A-clear, 5 B-set, 6 B-clear. A write leaves the active values unchanged until a transfer happens.
- R9: A `ldok_set` pulse raises `ldok` in the next cycle. With `reload_mode` 0 (immediate), the shadow values become active on the following clock and `ldok` returns to 0.
- R10: With `reload_mode` bit 0 set, a midpoint tick is an opportunity. With bit 1 set, a period-end tick is an opportunity. A transfer happens only on an opportunity while `ldok` is high. A transfer at a period end makes the new start value apply at once.
- R11: Opportunities are counted modulo `reload_freq`+1, and only every (`reload_freq`+1)th opportunity may transfer. `reload_freq` has no effect in immediate mode.
- R12: Without `ldok`, no opportunity transfers anything, and after a transfer `ldok` stays 0 until the next `ldok_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counting enable |
| prsc | input | PRSC_W | Prescale exponent, tick every 2^prsc cycles |
| reload_mode | input | 2 | 0 immediate, bit0 midpoint, bit1 period end |
| reload_freq | input | FREQ_W | Transfer on every (value+1)th opportunity |
| ldok_set | input | 1 | Request a shadow-to-active transfer |
| wr_en | input | 1 | Shadow write strobe |
| wr_sel | input | 3 | Shadow value select |
| wr_data | input | CNT_W | Shadow write data, signed |
| ldok | output | 1 | Transfer pending |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| half_stb | output | 1 | Midpoint strobe |
| full_stb | output | 1 | Period-end strobe |
| cnt | output | CNT_W | Counter value, signed |

## Verification
The hardest case to reach is a transfer that lands exactly at a period end on a counted opportunity. In that case the counter must take the new start value while the outputs still compare against the old set. To get there, the bench programs shadow values that differ from the active ones and sets load-ok in each cycle-based mode. It then sweeps the frequency divider so that transfers fall on midpoints, on period ends, and only on later opportunities. A cycle-accurate arithmetic model checks every output on every cycle.

// File: rtl/pwm_cmp_pkg.sv
`timescale 1ns/1ps
package pwm_cmp_pkg;
   // shadow and active value slots; the index is what wr_sel selects
   localparam int IDX_INIT  = 0;
   localparam int IDX_HALF  = 1;
   localparam int IDX_END   = 2;
   localparam int IDX_A_SET = 3;
   localparam int IDX_A_CLR = 4;
   localparam int IDX_B_SET = 5;
   localparam int IDX_B_CLR = 6;
   localparam int NUM_VALS  = 7;
   localparam int NUM_OUTS  = 2;

   typedef enum logic [1:0] {
      RL_IMM  = 2'b00,
      RL_HALF = 2'b01,
      RL_FULL = 2'b10,
      RL_BOTH = 2'b11
   } reload_mode_e;
endpackage

// File: rtl/pwm_tick_gen.sv
`timescale 1ns/1ps
module pwm_tick_gen #(
   parameter int PRSC_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [PRSC_W-1:0] prsc,
   output logic              tick
);
   localparam int DIV_W = (1 << PRSC_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   always_comb mask = DIV_W'((1 << prsc) - 1);

   assign tick = run && ((div_q & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n)    div_q <= '0;
      else if (!run) div_q <= '0;
      else           div_q <= div_q + {{(DIV_W-1){1'b0}}, 1'b1};
   end
endmodule

// File: rtl/pwm_sgn_counter.sv
`timescale 1ns/1ps
module pwm_sgn_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] init_val,
   input  logic [CNT_W-1:0] half_val,
   input  logic [CNT_W-1:0] end_val,
   output logic [CNT_W-1:0] cnt,
   output logic             half_hit,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;

   assign cnt      = cnt_q;
   assign wrap     = tick && (cnt_q == end_val);
   assign half_hit = tick && (cnt_q == half_val);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else if (tick) begin
         if (cnt_q == end_val) cnt_q <= init_val;
         else                  cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
      end
   end
endmodule

// File: rtl/pwm_reload_ctl.sv
`timescale 1ns/1ps
module pwm_reload_ctl
   import pwm_cmp_pkg::*;
#(
   parameter int FREQ_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [FREQ_W-1:0] freq,
   input  logic              ldok_set,
   input  logic              half_hit,
   input  logic              wrap,
   output logic              ldok,
   output logic              load
);
   logic              imm;
   logic              opp_ev;
   logic              opp_due;
   logic [FREQ_W-1:0] opp_q;
   logic              ldok_q;

   assign imm     = (mode == RL_IMM);
   assign opp_ev  = (mode[0] && half_hit) || (mode[1] && wrap);
   assign opp_due = opp_ev && (opp_q >= freq);
   assign load    = ldok_q && (imm || opp_due);
   assign ldok    = ldok_q;

   always_ff @(posedge clk) begin
      if (!rst_n) opp_q <= '0;
      else if (opp_ev) begin
         if (opp_due) opp_q <= '0;
         else         opp_q <= opp_q + {{(FREQ_W-1){1'b0}}, 1'b1};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        ldok_q <= 1'b0;
      else if (ldok_set) ldok_q <= 1'b1;
      else if (load)     ldok_q <= 1'b0;
   end
endmodule

// File: rtl/pwm_edge_out.sv
`timescale 1ns/1ps
module pwm_edge_out #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] set_val,
   input  logic [CNT_W-1:0] clr_val,
   output logic             out
);
   logic out_q;
   assign out = out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) out_q <= 1'b0;
      else if (tick) begin
         if (cnt == clr_val)      out_q <= 1'b0;
         else if (cnt == set_val) out_q <= 1'b1;
      end
   end
endmodule

// File: rtl/pwm_cmp_core.sv
`timescale 1ns/1ps
module pwm_cmp_core
   import pwm_cmp_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int PRSC_W = 3,
   parameter int FREQ_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [PRSC_W-1:0] prsc,
   input  logic [1:0]        reload_mode,
   input  logic [FREQ_W-1:0] reload_freq,
   input  logic              ldok_set,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [CNT_W-1:0]  wr_data,
   output logic              ldok,
   output logic              pwm_a,
   output logic              pwm_b,
   output logic              half_stb,
   output logic              full_stb,
   output logic [CNT_W-1:0]  cnt
);
   if (CNT_W < 4 || CNT_W > 32) begin : g_bad_cnt_w
      $error("pwm_cmp_core: CNT_W must lie in 4..32");
   end
   if (PRSC_W < 1 || PRSC_W > 4) begin : g_bad_prsc_w
      $error("pwm_cmp_core: PRSC_W must lie in 1..4");
   end
   if (FREQ_W < 1 || FREQ_W > 8) begin : g_bad_freq_w
      $error("pwm_cmp_core: FREQ_W must lie in 1..8");
   end

   logic [CNT_W-1:0] shd_q [NUM_VALS];
   logic [CNT_W-1:0] act_q [NUM_VALS];
   logic             tick;
   logic             wrap;
   logic             half_hit;
   logic             load;
   logic [CNT_W-1:0] init_nxt;
   logic [NUM_OUTS-1:0] pwm_vec;
   logic             half_q;
   logic             full_q;

   for (genvar i = 0; i < NUM_VALS; i++) begin : g_val
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shd_q[i] <= '0;
            act_q[i] <= '0;
         end else begin
            if (wr_en && (wr_sel == 3'(i))) shd_q[i] <= wr_data;
            if (load)                       act_q[i] <= shd_q[i];
         end
      end
   end

   // a transfer at the period end applies the new start value at once
   assign init_nxt = load ? shd_q[IDX_INIT] : act_q[IDX_INIT];

   pwm_tick_gen #(.PRSC_W(PRSC_W)) i_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .prsc  (prsc),
      .tick  (tick)
   );

   pwm_sgn_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .init_val (init_nxt),
      .half_val (act_q[IDX_HALF]),
      .end_val  (act_q[IDX_END]),
      .cnt      (cnt),
      .half_hit (half_hit),
      .wrap     (wrap)
   );

   pwm_reload_ctl #(.FREQ_W(FREQ_W)) i_rld (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (reload_mode),
      .freq     (reload_freq),
      .ldok_set (ldok_set),
      .half_hit (half_hit),
      .wrap     (wrap),
      .ldok     (ldok),
      .load     (load)
   );

   for (genvar k = 0; k < NUM_OUTS; k++) begin : g_out
      pwm_edge_out #(.CNT_W(CNT_W)) i_edge (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .cnt     (cnt),
         .set_val (act_q[IDX_A_SET + 2*k]),
         .clr_val (act_q[IDX_A_CLR + 2*k]),
         .out     (pwm_vec[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         half_q <= 1'b0;
         full_q <= 1'b0;
      end else begin
         half_q <= half_hit;
         full_q <= wrap;
      end
   end

   assign pwm_a    = pwm_vec[0];
   assign pwm_b    = pwm_vec[1];
   assign half_stb = half_q;
   assign full_stb = full_q;
endmodule

// File: rtl/pwm_cmp_core_chk.sv
`timescale 1ns/1ps
module pwm_cmp_core_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic [1:0]       reload_mode,
   input logic             ldok_set,
   input logic             ldok,
   input logic             pwm_a,
   input logic [CNT_W-1:0] cnt,
   input logic             tick,
   input logic             load,
   input logic [CNT_W-1:0] act_init,
   input logic [CNT_W-1:0] act_end,
   input logic [CNT_W-1:0] act_aclr
);
   // R4
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt));

   // R3
   wrap_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == act_end && !load) |=> (cnt == $past(act_init)));

   // R2
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt != act_end) |=> (cnt == CNT_W'($past(cnt) + 1)));

   // R6
   clr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == act_aclr) |=> !pwm_a);

   // R9
   imm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ldok && reload_mode == 2'b00 && !ldok_set) |=> !ldok);

   // R12
   load_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> ldok);
endmodule

bind pwm_cmp_core pwm_cmp_core_chk #(.CNT_W(CNT_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run         (run),
   .reload_mode (reload_mode),
   .ldok_set    (ldok_set),
   .ldok        (ldok),
   .pwm_a       (pwm_a),
   .cnt         (cnt),
   .tick        (tick),
   .load        (load),
   .act_init    (act_q[pwm_cmp_pkg::IDX_INIT]),
   .act_end     (act_q[pwm_cmp_pkg::IDX_END]),
   .act_aclr    (act_q[pwm_cmp_pkg::IDX_A_CLR])
);

// File: tb/test_pwm_cmp_core.sv
`timescale 1ns/1ps
module test_pwm_cmp_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [2:0]  prsc = '0;
   logic [1:0]  reload_mode = '0;
   logic [1:0]  reload_freq = '0;
   logic        ldok_set = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic        ldok, pwm_a, pwm_b, half_stb, full_stb;
   logic [15:0] cnt;

   int    n_chk = 0;
   int    n_err = 0;
   bit    chk_en = 1'b0;
   string cur_req = "R1";

   // model state, computed from the requirements
   logic [15:0] m_shd [7];
   logic [15:0] m_act [7];
   logic [15:0] m_cnt;
   int          m_div, m_opp;
   bit          m_ldok, m_a, m_b, m_h, m_f;
   bit          t_tk, t_wr, t_hh, t_ev, t_ld;
   int          t_mask;

   always #5 clk = ~clk;

   pwm_cmp_core i_pwm_cmp_core (
      .clk(clk), .rst_n(rst_n), .run(run), .prsc(prsc),
      .reload_mode(reload_mode), .reload_freq(reload_freq),
      .ldok_set(ldok_set), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .ldok(ldok), .pwm_a(pwm_a), .pwm_b(pwm_b),
      .half_stb(half_stb), .full_stb(full_stb), .cnt(cnt)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 7; i++) begin m_shd[i] = '0; m_act[i] = '0; end
         m_cnt = '0; m_div = 0; m_opp = 0;
         m_ldok = 0; m_a = 0; m_b = 0; m_h = 0; m_f = 0;
      end else begin
         t_mask = (1 << prsc) - 1;
         t_tk = run && ((m_div & t_mask) == t_mask);
         m_div = run ? m_div + 1 : 0;
         t_wr = t_tk && (m_cnt == m_act[2]);
         t_hh = t_tk && (m_cnt == m_act[1]);
         t_ev = (reload_mode[0] && t_hh) || (reload_mode[1] && t_wr);
         t_ld = m_ldok && (reload_mode == 2'b00 || (t_ev && m_opp >= int'(reload_freq)));
         if (t_ev) m_opp = (m_opp >= int'(reload_freq)) ? 0 : m_opp + 1;
         if (t_tk) begin
            if (m_cnt == m_act[4]) m_a = 0; else if (m_cnt == m_act[3]) m_a = 1;
            if (m_cnt == m_act[6]) m_b = 0; else if (m_cnt == m_act[5]) m_b = 1;
            m_cnt = t_wr ? (t_ld ? m_shd[0] : m_act[0]) : m_cnt + 16'd1;
         end
         m_h = t_hh;
         m_f = t_wr;
         if (t_ld) for (int i = 0; i < 7; i++) m_act[i] = m_shd[i];
         if (ldok_set) m_ldok = 1; else if (t_ld) m_ldok = 0;
         if (wr_en && wr_sel < 3'd7) m_shd[wr_sel] = wr_data;
      end
   end

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_en) begin
         chk(cnt === m_cnt,        "cnt R3",      cnt,      m_cnt);
         chk(pwm_a === m_a,        "pwm_a R5",    pwm_a,    m_a);
         chk(pwm_b === m_b,        "pwm_b R5",    pwm_b,    m_b);
         chk(half_stb === m_h,     "half_stb R7", half_stb, m_h);
         chk(full_stb === m_f,     "full_stb R7", full_stb, m_f);
         chk(ldok === m_ldok,      "ldok R9",     ldok,     m_ldok);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wreg(input int sel, input int val);
      wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 16'(val);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wcfg(input int i0, input int h, input int e,
                       input int as, input int ac, input int bs, input int bc);
      wreg(0, i0); wreg(1, h); wreg(2, e);
      wreg(3, as); wreg(4, ac); wreg(5, bs); wreg(6, bc);
   endtask

   task automatic set_ok();
      ldok_set = 1'b1;
      @(negedge clk);
      ldok_set = 1'b0;
   endtask

   initial begin
      #1ms;
      n_err++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      // R1 reset state
      cur_req = "R1";
      chk(cnt == 16'd0 && !pwm_a && !pwm_b, "R1 outputs", {cnt, pwm_a, pwm_b}, 0);
      chk(!half_stb && !full_stb && !ldok, "R1 strobes", {half_stb, full_stb, ldok}, 0);
      chk_en = 1'b1;

      // R8: shadow writes without load-ok leave the active set alone
      cur_req = "R8";
      wcfg(0, 5, 11, 0, 4, 3, 8);
      run = 1'b1; cyc(20); run = 1'b0;
      // R9: immediate transfer, then prescale sweep (R2)
      cur_req = "R9";
      reload_freq = 2'd3;
      set_ok(); cyc(4);
      cur_req = "R2";
      for (int p = 0; p < 4; p++) begin
         prsc = 3'(p); run = 1'b1; cyc(40 * (1 << p));
      end
      // R4: stopping freezes counter and outputs
      cur_req = "R4";
      run = 1'b0; cyc(15); run = 1'b1; cyc(20);
      prsc = 3'd0;

      // R10: signed centred set in each cycle-based mode
      cur_req = "R10";
      reload_freq = 2'd0;
      for (int m = 1; m < 4; m++) begin
         reload_mode = 2'(m);
         wcfg(-6, 0, 6, -2 - m, 2 + m, -4, m);
         set_ok(); cyc(60);
         prsc = 3'd1; cyc(40); prsc = 3'd0;
      end

      // R11: reload only on every (F+1)th opportunity
      cur_req = "R11";
      for (int f = 0; f < 4; f++) begin
         reload_freq = 2'(f);
         reload_mode = (f % 2 == 0) ? 2'b11 : 2'b10;
         wcfg(-5 + f, 0, 5 + f, -3, f, -1, 4);
         set_ok(); cyc(130);
      end

      // R6: set and clear on the same value
      cur_req = "R6";
      reload_mode = 2'b00; reload_freq = 2'd3;
      wcfg(0, 3, 9, 2, 2, 5, 5);
      set_ok(); cyc(60);

      // R12: no load-ok, new shadow values must stay inactive
      cur_req = "R12";
      reload_mode = 2'b11; reload_freq = 2'd0;
      wcfg(-20, -10, 20, -15, 15, 0, 10);
      cyc(80);
      set_ok(); cyc(100);

      chk_en = 1'b0;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule